// File: doc/BRIEF.md
# Serializer with Embedded Word Clock

This block turns 12-bit parallel words into a serial data line plus a source-synchronous bit clock. Every word is extended to a 14-bit frame: the data bits go out least significant bit first, followed by two boundary bits derived from the data MSB. The first boundary bit is the inverse of the MSB and the second equals it, so the data line always toggles twice at the end of a frame.

Framing is carried by the clock line itself rather than by a separate sync signal. During the two boundary bits the serial clock is not pulsed low, so a receiver sees an unusually long high stretch while the data line makes one rising and one falling transition. Both serial outputs come from registers clocked at twice the bit rate: each bit occupies two internal cycles, a low half and a high half, so the serial clock rises in the middle of every data bit.

Words are offered on a valid/ready handshake. The block takes a new word while idle, or in the final internal cycle of the last boundary bit, so that a continuously fed stream produces frames back to back with no idle gap.

Top module: `ser_embclk_tx`

## Requirements
- R1: The frame sent for word D is the 14-bit value {D[11], ~D[11], D[11:0]}, sent from bit 0 upward (data LSB first, D[11] twelfth, its inverse thirteenth, D[11] again last); 0xFFF is sent as 0x2FFF and 0x555 as 0x1555.
- R2: Each frame bit holds ser_data for two consecutive clk cycles; for the twelve data bits ser_clk is 0 in the first cycle and 1 in the second, so ser_data never changes in the cycle in which ser_clk rises.
- R3: During both boundary bits ser_clk stays 1 for all four cycles, so each frame carries exactly twelve rising edges of ser_clk and both boundary transitions of ser_data happen while ser_clk is 1.
- R4: in_ready is 1 while idle and in the second cycle of the last boundary bit, and 0 in every other cycle of a frame; a word is taken in a cycle where in_valid and in_ready are both 1.
- R5: The first bit of an accepted word appears on ser_data, with ser_clk 0, in the cycle after acceptance; a word taken during the last boundary bit therefore follows the previous frame with no gap.
- R6: With no word pending after a frame, ser_clk stays 1, ser_data keeps the value of the last boundary bit and in_ready stays 1.
- R7: While rst_n is 0 (asynchronous, active low, released through a two-stage synchronizer) ser_clk is 1, ser_data is 0 and in_ready is 1; a reset during a frame abandons it.
- R8: in_data and in_valid have no effect while in_ready is 0: the frame on the line is unaffected and no extra word is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is offered on in_data |
| in_data | input | 12 | Parallel data word |
| in_ready | output | 1 | The block takes the offered word this cycle |
| ser_clk | output | 1 | Serial bit clock with embedded word boundary |
| ser_data | output | 1 | Serial data line |

## Verification
The bench builds the block with its default data width of 12, giving a 14-bit frame of 28 internal cycles, so the all-ones and alternating example words and both MSB values are compared bit by bit and half by half against frames computed in the bench. That width also places the chained-handshake point on the final cycle of bit 14, where a second word is accepted while the first frame's last boundary bit is still on the line, with noise driven on in_data during the busy cycles before it.

// File: rtl/ser_pkg.sv
package ser_pkg;

  // Half of a serial bit period: the clock is low in the first half of a
  // data bit and high in the second.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } half_e;

  // Number of boundary bits appended to each word.
  localparam int unsigned BND_BITS = 2;

  // Default data word width.
  localparam int unsigned DEF_DW = 12;

endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ser_framer.sv
module ser_framer #(
  parameter int unsigned DW = ser_pkg::DEF_DW,
  localparam int unsigned FW = DW + ser_pkg::BND_BITS
) (
  input  logic [DW-1:0] data_i,
  output logic [FW-1:0] frame_o
);

  logic msb;
  assign msb = data_i[DW-1];

  // Data bits keep their positions; the frame is sent from bit 0 upward.
  for (genvar i = 0; i < DW; i++) begin : g_data
    assign frame_o[i] = data_i[i];
  end

  // First boundary bit forces a toggle away from the MSB, the second back.
  assign frame_o[DW]   = ~msb;
  assign frame_o[DW+1] = msb;

endmodule

// File: rtl/ser_seq.sv
module ser_seq
  import ser_pkg::*;
#(
  parameter int unsigned DW = DEF_DW,
  localparam int unsigned FW = DW + BND_BITS,
  localparam int unsigned CW = $clog2(FW)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load_o,
  output logic half_up_o,
  output logic adv_o,
  output logic next_bnd_o
);

  localparam logic [CW-1:0] LAST_IDX  = CW'(FW - 1);
  localparam logic [CW-1:0] LAST_DATA = CW'(DW - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] idx_q, idx_d;
  half_e         ph_q, ph_d;

  logic at_last_bit;
  logic at_final;

  assign at_last_bit = (idx_q == LAST_IDX);
  assign at_final    = busy_q && at_last_bit && (ph_q == PH_HIGH);

  assign in_ready   = !busy_q || at_final;
  assign load_o     = in_valid && in_ready;
  assign half_up_o  = busy_q && (ph_q == PH_LOW);
  assign adv_o      = busy_q && (ph_q == PH_HIGH) && !at_last_bit;
  assign next_bnd_o = (idx_q >= LAST_DATA);

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    ph_d   = ph_q;
    if (load_o) begin
      busy_d = 1'b1;
      idx_d  = '0;
      ph_d   = PH_LOW;
    end else if (half_up_o) begin
      ph_d   = PH_HIGH;
    end else if (adv_o) begin
      idx_d  = idx_q + 1'b1;
      ph_d   = PH_LOW;
    end else if (at_final) begin
      busy_d = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      ph_q   <= PH_LOW;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      ph_q   <= ph_d;
    end
  end

endmodule

// File: rtl/ser_out.sv
module ser_out #(
  parameter int unsigned DW = ser_pkg::DEF_DW,
  localparam int unsigned FW = DW + ser_pkg::BND_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          half_up_i,
  input  logic          adv_i,
  input  logic          next_bnd_i,
  input  logic [FW-1:0] frame_i,
  output logic          ser_clk,
  output logic          ser_data
);

  logic [FW-1:0] sh_q, sh_d;
  logic          sd_q, sd_d;
  logic          sc_q, sc_d;
  logic          sh_en;

  assign sh_en = load_i || adv_i;

  // Next-state logic
  always_comb begin
    sh_d = sh_q;
    sd_d = sd_q;
    sc_d = sc_q;
    if (load_i) begin
      sh_d = frame_i;
      sd_d = frame_i[0];
      sc_d = 1'b0;
    end else if (half_up_i) begin
      sc_d = 1'b1;
    end else if (adv_i) begin
      sh_d = {1'b0, sh_q[FW-1:1]};
      sd_d = sh_q[1];
      // Boundary bits keep the clock high: the low pulse is skipped.
      sc_d = next_bnd_i;
    end
  end

  // Shift register with a written-out enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q <= 1'b0;
      sc_q <= 1'b1;
    end else begin
      sd_q <= sd_d;
      sc_q <= sc_d;
    end
  end

  assign ser_clk  = sc_q;
  assign ser_data = sd_q;

endmodule

// File: rtl/ser_embclk_tx.sv
module ser_embclk_tx #(
  parameter int unsigned DW = ser_pkg::DEF_DW,
  localparam int unsigned FW = DW + ser_pkg::BND_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          ser_clk,
  output logic          ser_data
);

  logic          rst_sync_n;
  logic [FW-1:0] frame;
  logic          load;
  logic          half_up;
  logic          adv;
  logic          next_bnd;
  logic          ready_int;

  ser_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ser_framer #(.DW(DW)) u_framer (
    .data_i  (in_data),
    .frame_o (frame)
  );

  ser_seq #(.DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_valid   (in_valid),
    .in_ready   (ready_int),
    .load_o     (load),
    .half_up_o  (half_up),
    .adv_o      (adv),
    .next_bnd_o (next_bnd)
  );

  ser_out #(.DW(DW)) u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (load),
    .half_up_i  (half_up),
    .adv_i      (adv),
    .next_bnd_i (next_bnd),
    .frame_i    (frame),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data)
  );

  assign in_ready = ready_int;

endmodule

// File: rtl/ser_embclk_tx_chk.sv
module ser_embclk_tx_chk #(
  parameter int unsigned DW = ser_pkg::DEF_DW
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic ser_clk,
  input logic ser_data
);

  localparam int unsigned RW = $clog2(DW + 2) + 1;

  logic          prev_clk;
  logic [RW-1:0] rises;
  logic          accept;
  logic          rise_seen;

  assign accept    = in_valid && in_ready;
  assign rise_seen = ser_clk && !prev_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk <= 1'b1;
      rises    <= RW'(DW);
    end else begin
      prev_clk <= ser_clk;
      if (accept) begin
        rises <= '0;
      end else if (rise_seen) begin
        rises <= rises + 1'b1;
      end
    end
  end

  // R2: a low half of the serial clock lasts exactly one cycle
  a_r2_low_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |=> ser_clk);

  // R2: data is steady across each rising edge of the serial clock
  a_r2_data_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));

  // R3: no more than DW rising edges per frame
  a_r3_rise_limit: assert property (@(posedge clk) disable iff (!rst_n)
    rise_seen |-> (rises < RW'(DW)));

  // R4: a frame that has just started is not ready for another word
  a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R5: the first bit of a frame starts with a low clock half
  a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ser_clk);

  // R6: with nothing offered while ready, the line holds with clock high
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (ser_clk && $stable(ser_data) && in_ready));

endmodule

bind ser_embclk_tx ser_embclk_tx_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .ser_clk  (ser_clk),
  .ser_data (ser_data)
);

// File: tb/tb_ser_embclk_tx.sv
`timescale 1ns/1ps
module tb_ser_embclk_tx;

  localparam int DW = 12;
  localparam int FW = DW + 2;
  localparam int HALVES = 2 * FW;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_ready;
  logic          ser_clk;
  logic          ser_data;

  int n_checks;
  int n_fail;

  ser_embclk_tx #(.DW(DW)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .ser_clk  (ser_clk),
    .ser_data (ser_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] frame_of(input logic [DW-1:0] w);
    return {w[DW-1], ~w[DW-1], w};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    chk("R7", "clk in reset", 32'(ser_clk), 1);
    chk("R7", "data in reset", 32'(ser_data), 0);
    chk("R7", "ready in reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Offer a word while idle; returns at the negedge showing the first half.
  task automatic start(input logic [DW-1:0] w);
    @(negedge clk);
    chk("R4", "ready while idle", 32'(in_ready), 1);
    in_valid = 1'b1;
    in_data = w;
    @(negedge clk);
  endtask

  // Check one frame half by half; optionally chain word nw at the end,
  // driving noise on the inputs while the block is not ready.
  task automatic play(input logic [DW-1:0] w, input bit chain,
                      input logic [DW-1:0] nw, input string first_req);
    logic [FW-1:0] f;
    f = frame_of(w);
    for (int k = 0; k < HALVES; k++) begin
      int b;
      int p;
      b = k / 2;
      p = k % 2;
      chk((k == 0) ? first_req : "R1", $sformatf("data bit %0d", b),
          32'(ser_data), 32'(f[b]));
      if (b < DW)
        chk("R2", $sformatf("clk bit %0d half %0d", b, p), 32'(ser_clk), 32'(p));
      else
        chk("R3", $sformatf("clk boundary bit %0d half %0d", b, p),
            32'(ser_clk), 1);
      chk(chain ? "R8" : "R4", $sformatf("ready half %0d", k),
          32'(in_ready), (k == HALVES - 1) ? 1 : 0);
      if (chain) begin
        in_valid = 1'b1;
        in_data = (k == HALVES - 1) ? nw : (~nw ^ DW'(k * 7));
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_idle(input logic exp_data);
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R6", "idle clk", 32'(ser_clk), 1);
      chk("R6", "idle data", 32'(ser_data), 32'(exp_data));
      chk("R6", "idle ready", 32'(in_ready), 1);
      @(negedge clk);
    end
  endtask

  task automatic t_single(input logic [DW-1:0] w);
    logic [FW-1:0] f;
    f = frame_of(w);
    start(w);
    play(w, 1'b0, '0, "R5");
    check_idle(f[FW-1]);
  endtask

  task automatic t_examples();
    chk("R1", "frame of FFF", 32'(frame_of(12'hFFF)), 32'h2FFF);
    chk("R1", "frame of 555", 32'(frame_of(12'h555)), 32'h1555);
    t_single(12'hFFF);
    t_single(12'h555);
  endtask

  task automatic t_chain();
    logic [FW-1:0] f;
    start(12'hA5C);
    play(12'hA5C, 1'b1, 12'h3F1, "R5");
    play(12'h3F1, 1'b1, 12'h800, "R5");
    play(12'h800, 1'b0, '0, "R5");
    f = frame_of(12'h800);
    check_idle(f[FW-1]);
  endtask

  task automatic t_midreset();
    start(12'h7E3);
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7", "clk after mid-frame reset", 32'(ser_clk), 1);
    chk("R7", "data after mid-frame reset", 32'(ser_data), 0);
    chk("R7", "ready after mid-frame reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", "still idle after release", 32'(ser_clk), 1);
    t_single(12'h0F0);
  endtask

  bit done;

  initial begin
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    do_reset();
    t_examples();
    t_single(12'h000);
    t_single(12'h801);
    t_chain();
    t_midreset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule